// File: doc/BRIEF.md
# Control Register Write Unit

This block owns the processor's paging and mode control state: the machine control word (CR0), the translation base (CR3), the extension control word (CR4) and the extended feature register (EFER). A write port with a register select loads one of them per cycle. On every write the unit drops extension bits whose feature is not present, recomputes the hidden mode flags that the rest of the core reads in place of the raw registers, and raises a one-cycle translation-cache flush request only when a bit that changes address translation actually moves.

Turning paging on while long mode is enabled activates long mode. Turning it off while long mode is active leaves long mode, clears the 64-bit code flag and delivers a 32-bit-truncated copy of the current instruction pointer together with a one-cycle marker. A small state machine tracks the resulting operating mode in four states: `MODE_REAL` (protection off), `MODE_PROT` (protection on, paging off), `MODE_PAGED` (paging on, long mode inactive) and `MODE_LONG` (long mode active). On each write it moves to the state picked by priority from the new values: long-mode-active wins (transition *enter_long*), then paging (*enter_paged*, also *leave_long* when coming out of long mode), then protection (*enter_prot*), else *fall_to_real*. With no write it holds.

Top module: `ctlreg_write_unit`

## Requirements
- R1: Reset sets `cr0_o` to 0x10 (only bit 4, ET, set), zeroes `cr3_o`, `cr4_o`, `efer_o`, `hflags_o`, `flush_o`, `ip_o`, `ip_trunc_o`, and `mode_o` is 0 (`MODE_REAL`).
- R2: A write takes effect on the clock edge that samples `wr_en`; `wr_sel` 0 selects CR0, 1 CR3, 2 CR4, 3 EFER, and CR0/CR4 take `wr_data[31:0]`. An accepted CR0 write stores the data with bit 4 forced to 1, so `cr0_o[4]` is always 1.
- R3: An accepted CR0 write raises `flush_o` for exactly the following cycle if and only if bit 31 (PG), bit 16 (WP) or bit 0 (PE) differs from the old value.
- R4: After an accepted CR0 write, hidden flag bit 0 equals CR0 bit 0; hidden bit 1 (segment-base add) is set when the new bit 0 is 0 and otherwise keeps its value; hidden bits 2, 3, 4 copy CR0 bits 1, 2, 3.
- R5: A CR0 write that sets PG from 0 while EFER bit 8 (LME) is 1 sets EFER bit 10 (LMA) and hidden bit 5; if CR4 bit 5 (PAE) is 0 at that moment the whole write is dropped: no register, flag or flush changes.
- R6: A CR0 write that clears PG from 1 while EFER bit 10 is 1 clears EFER bit 10, hidden bits 5 and 6, and for one cycle asserts `ip_trunc_o` with `ip_o` equal to `ip_i[31:0]` zero-extended; otherwise `ip_o` follows `ip_i` one cycle late.
- R7: A CR3 write always stores `wr_data`; it raises `flush_o` only when the stored CR0 bit 31 is 1.
- R8: A CR4 write clears bit 9 unless feature 0, bit 21 unless feature 1, bit 11 unless feature 2, bit 22 unless feature 3, bit 24 unless feature 4, bit 28 unless feature 5; it raises `flush_o` if the written value differs from the old CR4 in bit 4, 5, 7, 12, 20 or 21.
- R9: A CR4 write sets hidden bits 7, 8, 9 from the masked CR4 bits 9, 21, 11, and hidden bit 10 to masked CR4 bit 18 AND `xcr0_i` bit 1 AND `xcr0_i` bit 2.
- R10: An EFER write stores `wr_data`, sets hidden bit 5 from its bit 10 and hidden bit 11 from its bit 12, and raises no flush.
- R11: `seg_long_i` sets hidden bit 6 on the next edge only when hidden bit 5 (after any write in the same cycle) is 1; otherwise it has no effect.
- R12: `mode_o` is 3 when EFER bit 10 is 1, else 2 when CR0 bit 31 is 1, else 1 when CR0 bit 0 is 1, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select (0 CR0, 1 CR3, 2 CR4, 3 EFER) |
| wr_data | input | XLEN | Write data |
| feat_i | input | 6 | Supported-feature vector |
| xcr0_i | input | XLEN | Extended state enable register value |
| ip_i | input | XLEN | Current instruction pointer |
| seg_long_i | input | 1 | Request to mark the code segment as 64-bit |
| cr0_o | output | 32 | Stored CR0 |
| cr3_o | output | XLEN | Stored CR3 |
| cr4_o | output | 32 | Stored CR4 |
| efer_o | output | XLEN | Stored EFER |
| hflags_o | output | 12 | Hidden mode flags |
| mode_o | output | 2 | Operating mode state |
| flush_o | output | 1 | One-cycle translation flush request |
| ip_o | output | XLEN | Registered, possibly truncated, instruction pointer |
| ip_trunc_o | output | 1 | One-cycle marker of a truncation |

## Verification
On every cycle the assertions hold the ET bit set, tie the PE and long-mode-active hidden flags to their register bits, keep the AVX flag behind the stored OSXSAVE bit, bound the mode state by long-mode activity, and forbid a flush without a preceding write or after a CR3 write with paging off. Which bits trigger a flush, the feature masking of each CR4 bit, the dropped long-mode entry without PAE, the instruction-pointer truncation and the retention of the segment-add flag are shown only by the bench's sweeps against its own model of the write rules.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    // CR0 bit positions
    localparam int C0_PE = 0;
    localparam int C0_MP = 1;
    localparam int C0_EM = 2;
    localparam int C0_TS = 3;
    localparam int C0_ET = 4;
    localparam int C0_WP = 16;
    localparam int C0_PG = 31;

    // CR4 bit positions
    localparam int C4_PSE     = 4;
    localparam int C4_PAE     = 5;
    localparam int C4_PGE     = 7;
    localparam int C4_OSFXSR  = 9;
    localparam int C4_UMIP    = 11;
    localparam int C4_LA57    = 12;
    localparam int C4_OSXSAVE = 18;
    localparam int C4_SMEP    = 20;
    localparam int C4_SMAP    = 21;
    localparam int C4_PKE     = 22;
    localparam int C4_PKS     = 24;
    localparam int C4_LAMS    = 28;

    // EFER bit positions
    localparam int EF_LME  = 8;
    localparam int EF_LMA  = 10;
    localparam int EF_SVME = 12;

    // extended state enable bits
    localparam int XC_SSE = 1;
    localparam int XC_YMM = 2;

    // feature vector layout
    localparam int FT_SSE  = 0;
    localparam int FT_SMAP = 1;
    localparam int FT_UMIP = 2;
    localparam int FT_PKU  = 3;
    localparam int FT_PKS  = 4;
    localparam int FT_LAM  = 5;
    localparam int NUM_FEAT = 6;

    // CR4 bit gated by each feature, indexed by feature number
    localparam int FEAT_GATED_BIT [NUM_FEAT] = '{C4_OSFXSR, C4_SMAP, C4_UMIP,
                                                 C4_PKE, C4_PKS, C4_LAMS};

    localparam logic [31:0] C0_XLATE_MASK =
        (32'h1 << C0_PG) | (32'h1 << C0_WP) | (32'h1 << C0_PE);
    localparam logic [31:0] C4_XLATE_MASK =
        (32'h1 << C4_PGE) | (32'h1 << C4_PAE) | (32'h1 << C4_PSE) |
        (32'h1 << C4_SMEP) | (32'h1 << C4_SMAP) | (32'h1 << C4_LA57);

    typedef enum logic [1:0] {
        SEL_CR0  = 2'd0,
        SEL_CR3  = 2'd1,
        SEL_CR4  = 2'd2,
        SEL_EFER = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_REAL  = 2'd0,
        MODE_PROT  = 2'd1,
        MODE_PAGED = 2'd2,
        MODE_LONG  = 2'd3
    } mode_e;

    // packed MSB first: pe lands in bit 0
    typedef struct packed {
        logic svme;    // 11
        logic avx;     // 10
        logic umip;    // 9
        logic smap;    // 8
        logic osfxsr;  // 7
        logic cs64;    // 6
        logic lma;     // 5
        logic ts;      // 4
        logic em;      // 3
        logic mp;      // 2
        logic addseg;  // 1
        logic pe;      // 0
    } hflags_t;

    localparam int HF_W = $bits(hflags_t);

endpackage

// File: rtl/ctlreg_cr0_path.sv
module ctlreg_cr0_path
    import ctlreg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]     cr0_old,
    input  logic [XLEN-1:0] efer_old,
    input  logic            pae_now,
    input  hflags_t         hf_old,
    input  logic [31:0]     wdata,
    output logic            accept,
    output logic [31:0]     cr0_new,
    output logic [XLEN-1:0] efer_new,
    output hflags_t         hf_new,
    output logic            flush,
    output logic            lm_exit
);

    logic pg_rise;
    logic pg_fall;
    logic lm_enter;

    always_comb begin
        pg_rise  = !cr0_old[C0_PG] && wdata[C0_PG];
        pg_fall  = cr0_old[C0_PG] && !wdata[C0_PG];
        lm_enter = pg_rise && efer_old[EF_LME];
        accept   = !(lm_enter && !pae_now);

        cr0_new  = cr0_old;
        efer_new = efer_old;
        hf_new   = hf_old;
        flush    = 1'b0;
        lm_exit  = 1'b0;

        if (accept) begin
            lm_exit = pg_fall && efer_old[EF_LMA];
            flush   = |((wdata ^ cr0_old) & C0_XLATE_MASK);
            if (lm_enter) begin
                efer_new[EF_LMA] = 1'b1;
                hf_new.lma       = 1'b1;
            end
            if (lm_exit) begin
                efer_new[EF_LMA] = 1'b0;
                hf_new.lma       = 1'b0;
                hf_new.cs64      = 1'b0;
            end
            cr0_new          = wdata;
            cr0_new[C0_ET]   = 1'b1;
            hf_new.pe        = wdata[C0_PE];
            if (!wdata[C0_PE]) begin
                hf_new.addseg = 1'b1;
            end
            hf_new.mp        = wdata[C0_MP];
            hf_new.em        = wdata[C0_EM];
            hf_new.ts        = wdata[C0_TS];
        end
    end

endmodule

// File: rtl/ctlreg_cr4_path.sv
module ctlreg_cr4_path
    import ctlreg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]         cr4_old,
    input  logic [31:0]         wdata,
    input  logic [NUM_FEAT-1:0] feat,
    input  logic [XLEN-1:0]     xcr0,
    input  hflags_t             hf_old,
    output logic [31:0]         cr4_new,
    output hflags_t             hf_new,
    output logic                flush
);

    localparam logic [XLEN-1:0] XC_NEED =
        (XLEN'(1) << XC_SSE) | (XLEN'(1) << XC_YMM);

    logic [31:0] kill [NUM_FEAT];
    logic [31:0] kill_all;

    for (genvar k = 0; k < NUM_FEAT; k++) begin : g_gate
        assign kill[k] = feat[k] ? 32'h0 : (32'h1 << FEAT_GATED_BIT[k]);
    end

    always_comb begin
        kill_all = 32'h0;
        for (int k = 0; k < NUM_FEAT; k++) begin
            kill_all = kill_all | kill[k];
        end
        cr4_new       = wdata & ~kill_all;
        flush         = |((wdata ^ cr4_old) & C4_XLATE_MASK);
        hf_new        = hf_old;
        hf_new.osfxsr = cr4_new[C4_OSFXSR];
        hf_new.smap   = cr4_new[C4_SMAP];
        hf_new.umip   = cr4_new[C4_UMIP];
        hf_new.avx    = cr4_new[C4_OSXSAVE] && ((xcr0 & XC_NEED) == XC_NEED);
    end

endmodule

// File: rtl/ctlreg_mode_fsm.sv
module ctlreg_mode_fsm
    import ctlreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd,
    input  logic  pe_next,
    input  logic  pg_next,
    input  logic  lma_next,
    output mode_e mode
);

    mode_e state;
    mode_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MODE_REAL;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (upd) begin
            unique case (state)
                MODE_REAL, MODE_PROT, MODE_PAGED, MODE_LONG: begin
                    if (lma_next) begin
                        state_nxt = MODE_LONG;       // enter_long
                    end else if (pg_next) begin
                        state_nxt = MODE_PAGED;      // enter_paged / leave_long
                    end else if (pe_next) begin
                        state_nxt = MODE_PROT;       // enter_prot
                    end else begin
                        state_nxt = MODE_REAL;       // fall_to_real
                    end
                end
                default: state_nxt = MODE_REAL;
            endcase
        end
    end

    always_comb begin
        mode = state;
    end

endmodule

// File: rtl/ctlreg_write_unit.sv
module ctlreg_write_unit
    import ctlreg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [XLEN-1:0]     wr_data,
    input  logic [NUM_FEAT-1:0] feat_i,
    input  logic [XLEN-1:0]     xcr0_i,
    input  logic [XLEN-1:0]     ip_i,
    input  logic                seg_long_i,
    output logic [31:0]         cr0_o,
    output logic [XLEN-1:0]     cr3_o,
    output logic [31:0]         cr4_o,
    output logic [XLEN-1:0]     efer_o,
    output logic [HF_W-1:0]     hflags_o,
    output logic [1:0]          mode_o,
    output logic                flush_o,
    output logic [XLEN-1:0]     ip_o,
    output logic                ip_trunc_o
);

    localparam logic [XLEN-1:0] LOW32 = XLEN'(33'h0_FFFF_FFFF);
    localparam logic [31:0]     CR0_RST = 32'h1 << C0_ET;

    reg_sel_e        sel;
    logic [31:0]     cr0_q, cr4_q, cr0_n, cr4_n;
    logic [XLEN-1:0] cr3_q, efer_q, cr3_n, efer_n, ip_n;
    hflags_t         hf_q, hf_n;
    logic            flush_n, exit_n;

    logic            c0_accept, c0_flush, c0_exit;
    logic [31:0]     c0_cr0;
    logic [XLEN-1:0] c0_efer;
    hflags_t         c0_hf;
    logic [31:0]     c4_cr4;
    hflags_t         c4_hf;
    logic            c4_flush;
    mode_e           mode_s;

    assign sel = reg_sel_e'(wr_sel);

    ctlreg_cr0_path #(.XLEN(XLEN)) u_cr0 (
        .cr0_old  (cr0_q),
        .efer_old (efer_q),
        .pae_now  (cr4_q[C4_PAE]),
        .hf_old   (hf_q),
        .wdata    (wr_data[31:0]),
        .accept   (c0_accept),
        .cr0_new  (c0_cr0),
        .efer_new (c0_efer),
        .hf_new   (c0_hf),
        .flush    (c0_flush),
        .lm_exit  (c0_exit)
    );

    ctlreg_cr4_path #(.XLEN(XLEN)) u_cr4 (
        .cr4_old (cr4_q),
        .wdata   (wr_data[31:0]),
        .feat    (feat_i),
        .xcr0    (xcr0_i),
        .hf_old  (hf_q),
        .cr4_new (c4_cr4),
        .hf_new  (c4_hf),
        .flush   (c4_flush)
    );

    always_comb begin
        cr0_n   = cr0_q;
        cr3_n   = cr3_q;
        cr4_n   = cr4_q;
        efer_n  = efer_q;
        hf_n    = hf_q;
        flush_n = 1'b0;
        exit_n  = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_CR0: begin
                    if (c0_accept) begin
                        cr0_n   = c0_cr0;
                        efer_n  = c0_efer;
                        hf_n    = c0_hf;
                        flush_n = c0_flush;
                        exit_n  = c0_exit;
                    end
                end
                SEL_CR3: begin
                    cr3_n   = wr_data;
                    flush_n = cr0_q[C0_PG];
                end
                SEL_CR4: begin
                    cr4_n   = c4_cr4;
                    hf_n    = c4_hf;
                    flush_n = c4_flush;
                end
                SEL_EFER: begin
                    efer_n    = wr_data;
                    hf_n.lma  = wr_data[EF_LMA];
                    hf_n.svme = wr_data[EF_SVME];
                end
                default: ;
            endcase
        end
        if (seg_long_i && hf_n.lma) begin
            hf_n.cs64 = 1'b1;
        end
        ip_n = exit_n ? (ip_i & LOW32) : ip_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr0_q      <= CR0_RST;
            cr3_q      <= '0;
            cr4_q      <= '0;
            efer_q     <= '0;
            hf_q       <= '0;
            flush_o    <= 1'b0;
            ip_o       <= '0;
            ip_trunc_o <= 1'b0;
        end else begin
            cr0_q      <= cr0_n;
            cr3_q      <= cr3_n;
            cr4_q      <= cr4_n;
            efer_q     <= efer_n;
            hf_q       <= hf_n;
            flush_o    <= flush_n;
            ip_o       <= ip_n;
            ip_trunc_o <= exit_n;
        end
    end

    ctlreg_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (wr_en),
        .pe_next  (cr0_n[C0_PE]),
        .pg_next  (cr0_n[C0_PG]),
        .lma_next (hf_n.lma),
        .mode     (mode_s)
    );

    assign cr0_o    = cr0_q;
    assign cr3_o    = cr3_q;
    assign cr4_o    = cr4_q;
    assign efer_o   = efer_q;
    assign hflags_o = hf_q;
    assign mode_o   = mode_s;

    // ---------------- assertions ----------------
    assert_et_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_o[C0_ET]);

    assert_flush_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(wr_en));

    assert_pe_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hf_q.pe == cr0_q[C0_PE]);

    assert_trunc_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ip_trunc_o |-> ((ip_o & ~LOW32) == '0));

    assert_cr3_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CR3 && !cr0_q[C0_PG]) |=> !flush_o);

    assert_sse_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CR4 && !feat_i[FT_SSE]) |=> !cr4_o[C4_OSFXSR]);

    assert_avx_osxsave_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hf_q.avx |-> cr4_q[C4_OSXSAVE]);

    assert_lma_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hf_q.lma == efer_q[EF_LMA]);

    assert_long_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hf_q.lma |-> (mode_s == MODE_LONG));

endmodule

// File: tb/ctlreg_write_unit_bench.sv
`timescale 1ns/1ps
module ctlreg_write_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [63:0] wr_data = '0;
    logic [5:0]  feat_i = 6'h3F;
    logic [63:0] xcr0_i = '0;
    logic [63:0] ip_i = 64'hA5C3_0F1E_1234_5678;
    logic        seg_long_i = 1'b0;
    logic [31:0] cr0_o, cr4_o;
    logic [63:0] cr3_o, efer_o, ip_o;
    logic [11:0] hflags_o;
    logic [1:0]  mode_o;
    logic        flush_o, ip_trunc_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model
    logic [31:0] m_cr0, m_cr4;
    logic [63:0] m_cr3, m_efer, m_ip;
    logic [11:0] m_hf;
    logic        m_flush, m_iptr;

    always #2 clk = ~clk;

    ctlreg_write_unit u_ctlreg_write_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .feat_i(feat_i), .xcr0_i(xcr0_i), .ip_i(ip_i),
        .seg_long_i(seg_long_i), .cr0_o(cr0_o), .cr3_o(cr3_o), .cr4_o(cr4_o),
        .efer_o(efer_o), .hflags_o(hflags_o), .mode_o(mode_o),
        .flush_o(flush_o), .ip_o(ip_o), .ip_trunc_o(ip_trunc_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode();
        return m_efer[10] ? 2'd3 : m_cr0[31] ? 2'd2 : m_cr0[0] ? 2'd1 : 2'd0;
    endfunction

    task automatic check_all();
        chk("R2 cr0", 64'(cr0_o), 64'(m_cr0));
        chk("R7 cr3", cr3_o, m_cr3);
        chk("R8 cr4", 64'(cr4_o), 64'(m_cr4));
        chk("R10 efer", efer_o, m_efer);
        chk("R4 hflags[4:0]", 64'(hflags_o[4:0]), 64'(m_hf[4:0]));
        chk("R5 hflags[6:5]", 64'(hflags_o[6:5]), 64'(m_hf[6:5]));
        chk("R9 hflags[10:7]", 64'(hflags_o[10:7]), 64'(m_hf[10:7]));
        chk("R10 hflags[11]", 64'(hflags_o[11]), 64'(m_hf[11]));
        chk("R3 flush", 64'(flush_o), 64'(m_flush));
        chk("R12 mode", 64'(mode_o), 64'(exp_mode()));
        chk("R6 ip", ip_o, m_ip);
        chk("R6 ip_trunc", 64'(ip_trunc_o), 64'(m_iptr));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; seg_long_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cr0 = 32'h10; m_cr3 = '0; m_cr4 = '0; m_efer = '0; m_hf = '0;
        m_flush = 1'b0; m_iptr = 1'b0; m_ip = '0;
    endtask

    task automatic model_write(input logic [1:0] s, input logic [63:0] d);
        logic        enter, exitlm;
        logic [31:0] d32, m4;
        d32 = d[31:0];
        m_flush = 1'b0; m_iptr = 1'b0;
        enter = 1'b0; exitlm = 1'b0;
        case (s)
            2'd0: begin
                enter = !m_cr0[31] && d32[31] && m_efer[8];
                if (!(enter && !m_cr4[5])) begin
                    exitlm  = m_cr0[31] && !d32[31] && m_efer[10];
                    m_flush = (d32[31] != m_cr0[31]) || (d32[16] != m_cr0[16]) ||
                              (d32[0] != m_cr0[0]);
                    if (enter) begin m_efer[10] = 1'b1; m_hf[5] = 1'b1; end
                    if (exitlm) begin
                        m_efer[10] = 1'b0; m_hf[5] = 1'b0; m_hf[6] = 1'b0; m_iptr = 1'b1;
                    end
                    m_cr0 = d32 | 32'h10;
                    m_hf[0] = d32[0];
                    if (!d32[0]) m_hf[1] = 1'b1;
                    m_hf[2] = d32[1]; m_hf[3] = d32[2]; m_hf[4] = d32[3];
                end
            end
            2'd1: begin m_cr3 = d; m_flush = m_cr0[31]; end
            2'd2: begin
                m_flush = (d32[4] != m_cr4[4]) || (d32[5] != m_cr4[5]) ||
                          (d32[7] != m_cr4[7]) || (d32[12] != m_cr4[12]) ||
                          (d32[20] != m_cr4[20]) || (d32[21] != m_cr4[21]);
                m4 = d32;
                if (!feat_i[0]) m4[9]  = 1'b0;
                if (!feat_i[1]) m4[21] = 1'b0;
                if (!feat_i[2]) m4[11] = 1'b0;
                if (!feat_i[3]) m4[22] = 1'b0;
                if (!feat_i[4]) m4[24] = 1'b0;
                if (!feat_i[5]) m4[28] = 1'b0;
                m_cr4 = m4;
                m_hf[7] = m4[9]; m_hf[8] = m4[21]; m_hf[9] = m4[11];
                m_hf[10] = m4[18] && xcr0_i[1] && xcr0_i[2];
            end
            default: begin m_efer = d; m_hf[5] = d[10]; m_hf[11] = d[12]; end
        endcase
        m_ip = m_iptr ? {32'h0, ip_i[31:0]} : ip_i;
    endtask

    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        model_write(s, d);
        wr_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check_all();
    endtask

    task automatic seg_pulse();
        m_flush = 1'b0; m_iptr = 1'b0; m_ip = ip_i;
        if (m_hf[5]) m_hf[6] = 1'b1;
        seg_long_i = 1'b1;
        @(negedge clk);
        seg_long_i = 1'b0;
        chk("R11 cs64", 64'(hflags_o[6]), 64'(m_hf[6]));
        check_all();
    endtask

    task automatic idle();
        m_flush = 1'b0; m_iptr = 1'b0; m_ip = ip_i;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 cr0", 64'(cr0_o), 64'h10);
        chk("R1 cr3", cr3_o, 64'h0);
        chk("R1 cr4", 64'(cr4_o), 64'h0);
        chk("R1 efer", efer_o, 64'h0);
        chk("R1 hflags", 64'(hflags_o), 64'h0);
        chk("R1 flush", 64'(flush_o), 64'h0);
        chk("R1 mode", 64'(mode_o), 64'h0);
        chk("R1 ip", ip_o, 64'h0);
        chk("R1 ip_trunc", 64'(ip_trunc_o), 64'h0);

        // R2 R3 R4 R12: sweep CR0 over PE, MP, EM, TS, WP, PG (no long mode)
        for (int i = 0; i < 64; i++) begin
            wr(2'd0, {32'h0, i[5], 14'h0, i[4], 12'h0, i[3:0]} | 64'h0000_0000_00F0_0100);
        end
        for (int i = 63; i >= 0; i--) begin
            wr(2'd0, {32'h0, i[5], 14'h0, i[4], 12'h0, i[3:0]});
        end

        // R7: CR3 with paging off then on
        do_reset();
        wr(2'd1, 64'h0000_0012_3456_7000);
        wr(2'd0, 64'h8000_0001);
        wr(2'd1, 64'hFFFF_FFFF_FFFF_F000);
        wr(2'd1, 64'hFFFF_FFFF_FFFF_F000);

        // R8 R9: every feature combination, all-ones and zero CR4
        do_reset();
        xcr0_i = 64'h7;
        for (int f = 0; f < 64; f++) begin
            feat_i = f[5:0];
            wr(2'd2, 64'hFFFF_FFFF);
            wr(2'd2, 64'h0);
        end
        feat_i = 6'h3F;
        // R8 single flush bits
        for (int b = 0; b < 32; b++) begin
            wr(2'd2, 64'(32'h1 << b));
        end

        // R9 AVX: every XCR0 low-bit combination with OSXSAVE on and off
        for (int x = 0; x < 8; x++) begin
            xcr0_i = 64'(x);
            wr(2'd2, 64'(32'h1 << 18));
            wr(2'd2, 64'h0);
        end
        xcr0_i = 64'h7;

        // R10: EFER combinations
        do_reset();
        for (int e = 0; e < 8; e++) begin
            wr(2'd3, {51'h0, e[2], 1'b0, e[1], 1'b0, e[0], 8'h0});
        end

        // R5 R6 R11: long-mode sequence
        do_reset();
        seg_pulse();                  // R11: no effect without long mode
        wr(2'd3, 64'h100);            // LME
        wr(2'd0, 64'h8000_0001);      // R5: dropped, PAE clear
        wr(2'd2, 64'h20);             // PAE on
        wr(2'd0, 64'h8000_0001);      // R5: enter long mode
        seg_pulse();                  // R11: cs64 set
        idle();
        wr(2'd0, 64'h0000_0001);      // R6: leave long mode
        idle();                       // R6: marker gone, ip full again
        wr(2'd0, 64'h8000_0001);      // re-enter
        ip_i = 64'hFFFF_FFFF_FFFF_FFFF;
        idle();
        wr(2'd0, 64'h0000_0000);      // R6 exit with all-ones ip
        wr(2'd0, 64'h0000_0001);      // R4: segment-add flag retained

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule